// File: doc/BRIEF.md
# Coprime-Ring Time Interval Digitizer

This block measures how many delay ticks elapse between a start event and a stop event. A single delay line as long as the whole range would need one stage and one flip-flop per count. Here the block uses a small set of short phase rings instead. Each ring has its own length, and the lengths share no common factor. In RTL every ring is a one-hot phase register. All rings step forward on a shared delay-tick enable while the measurement window is open.

A start event clears every ring to phase 0 and opens the window. A stop event freezes a copy of every ring's phase and closes the window. Each frozen phase is turned into a residue. The residues are then merged into one count k with a Chinese-remainder weighted sum. For the default lengths 2, 3 and 5, the block stores only 10 phase bits but covers an unambiguous range of 30 counts. In general it stores the sum of the lengths and covers their product.

Top module: `crt_interval_digitizer`

## Requirements
- R1: After reset, valid_o is 0, count_o is 0, every residue is 0, and every ring's captured phase is phase 0.
- R2: A cycle with start high clears all rings to phase 0 and opens the window. A tick in that same cycle is not counted. Ticks seen while the window is closed change no ring.
- R3: Each cycle with tick_en high, the window open, and neither start nor stop high, advances every ring by one phase. The count reported after stop equals the number of such cycles mod N (N = product of the lengths, 30 by default). It therefore rises by one per tick and wraps to 0 after N ticks.
- R4: residue_o field i, at bits [i*RW +: RW] with RW = 3 by default, equals count_o mod the length of ring i. Ring 0 has length 2, ring 1 has length 3 and ring 2 has length 5.
- R5: ring_phase_o is the concatenation of the captured one-hot rings, with ring 0 in the lowest bits. Ring i occupies bits [sum of the earlier lengths +: its length], and bit j set means phase j. By default this is bits [1:0], [4:2] and [9:5].
- R6: valid_o is high for exactly one cycle, the cycle after an accepted stop. ring_phase_o, residue_o and count_o change only with an accepted stop and hold their values otherwise.
- R7: A stop while the window is closed is ignored: valid_o stays 0 and all outputs keep their values.
- R8: When start and stop are high in the same cycle, start wins: the rings restart, the window stays open, and no result is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Delay-tick enable shared by all rings |
| start | input | 1 | Clears the rings and opens the window |
| stop | input | 1 | Captures the ring phases and closes the window |
| ring_phase_o | output | 10 | Captured one-hot ring phases, ring 0 in the low bits |
| residue_o | output | 9 | Captured residues, RW bits per ring |
| count_o | output | 5 | Recombined interval count k |
| valid_o | output | 1 | One-cycle pulse when a new result is available |

## Verification
The assertions take for granted that start, stop and tick_en are clean, synchronous single-cycle levels. They also assume that any stop worth reporting comes while the window is open and without a simultaneous start. The rules on stray and colliding stops are what make a pulse on valid_o one cycle wide.

The stimulus drives every input at the falling edge, so no input moves near the active edge. Ticks are randomly thinned, and some land on the start and stop cycles to probe the rules on which ticks count. Stray stops and start/stop collisions are issued on purpose, and each time the bench checks that the outputs stay untouched.

// File: rtl/cid_pkg.sv
package cid_pkg;

    localparam int unsigned MAX_RINGS = 8;
    typedef logic [MAX_RINGS*8-1:0] mods_t;

    function automatic int unsigned mod_of(mods_t m, int unsigned i);
        return int'(m[i*8 +: 8]);
    endfunction

    function automatic int unsigned mods_product(mods_t m, int unsigned nr);
        int unsigned p;
        p = 1;
        for (int unsigned i = 0; i < nr; i++) p = p * mod_of(m, i);
        return p;
    endfunction

    function automatic int unsigned mods_offset(mods_t m, int unsigned upto);
        int unsigned s;
        s = 0;
        for (int unsigned i = 0; i < upto; i++) s = s + mod_of(m, i);
        return s;
    endfunction

    function automatic int unsigned mods_max(mods_t m, int unsigned nr);
        int unsigned x;
        x = 0;
        for (int unsigned i = 0; i < nr; i++)
            if (mod_of(m, i) > x) x = mod_of(m, i);
        return x;
    endfunction

    // Weight w_i = (N/m_i) * inverse of (N/m_i) modulo m_i
    function automatic int unsigned crt_weight(mods_t m, int unsigned nr, int unsigned i);
        int unsigned n;
        int unsigned mi;
        int unsigned ni;
        int unsigned w;
        n  = mods_product(m, nr);
        mi = mod_of(m, i);
        ni = n / mi;
        w  = 0;
        for (int unsigned t = 1; t < mi; t++)
            if (w == 0 && ((ni * t) % mi) == 1) w = ni * t;
        return w;
    endfunction

endpackage

// File: rtl/cid_ring.sv
module cid_ring #(
    parameter int unsigned LEN = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clear,
    input  logic           adv,
    input  logic           capture,
    output logic [LEN-1:0] cap_o
);

    typedef struct packed {
        logic [LEN-1:0] ring;
        logic [LEN-1:0] cap;
    } ring_st_t;

    localparam logic [LEN-1:0] PHASE0 = LEN'(1);

    ring_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear)
            st_d.ring = PHASE0;
        else if (adv)
            st_d.ring = {st_q.ring[LEN-2:0], st_q.ring[LEN-1]};
        if (capture)
            st_d.cap = st_q.ring;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ring <= PHASE0;
            st_q.cap  <= PHASE0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cap_o = st_q.cap;

    // R3: the live ring always holds exactly one phase
    a_r3_ring_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(st_q.ring) == 1);

    // R2: a clear lands on phase 0
    a_r2_clear_phase0: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> st_q.ring[0]);

    // R2: without clear or advance the ring does not move
    a_r2_ring_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !adv) |=> $stable(st_q.ring));

    // R6: the captured phase only changes on capture
    a_r6_cap_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(st_q.cap));

endmodule

// File: rtl/cid_decode.sv
module cid_decode #(
    parameter int unsigned LEN = 3,
    parameter int unsigned RW  = 2
) (
    input  logic [LEN-1:0] onehot,
    output logic [RW-1:0]  idx
);

    always_comb begin
        idx = '0;
        for (int j = 0; j < int'(LEN); j++)
            if (onehot[j]) idx = RW'(j);
    end

endmodule

// File: rtl/cid_combine.sv
module cid_combine
    import cid_pkg::*;
#(
    parameter int unsigned NR   = 3,
    parameter mods_t       MODS = '0,
    parameter int unsigned RW   = 3,
    parameter int unsigned KW   = 5
) (
    input  logic [NR*RW-1:0] res_i,
    output logic [KW-1:0]    k_o
);

    localparam int unsigned N = mods_product(MODS, NR);

    logic [31:0] acc;

    always_comb begin
        acc = '0;
        for (int unsigned i = 0; i < NR; i++)
            acc = (acc + (32'(res_i[i*RW +: RW]) * crt_weight(MODS, NR, i)) % N) % N;
        k_o = acc[KW-1:0];
    end

endmodule

// File: rtl/crt_interval_digitizer.sv
module crt_interval_digitizer
    import cid_pkg::*;
#(
    parameter int unsigned NR   = 3,
    parameter mods_t       MODS = {40'd0, 8'd5, 8'd3, 8'd2},
    parameter int unsigned N    = mods_product(MODS, NR),
    parameter int unsigned M    = mods_offset(MODS, NR),
    parameter int unsigned RW   = $clog2(mods_max(MODS, NR)),
    parameter int unsigned KW   = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_en,
    input  logic            start,
    input  logic            stop,
    output logic [M-1:0]    ring_phase_o,
    output logic [NR*RW-1:0] residue_o,
    output logic [KW-1:0]   count_o,
    output logic            valid_o
);

    typedef struct packed {
        logic open;
        logic valid;
    } ctl_st_t;

    ctl_st_t st_d, st_q;
    logic    clear, adv, capture;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        clear      = start;
        capture    = stop && st_q.open && !start;
        adv        = tick_en && st_q.open && !start && !stop;
        if (start)
            st_d.open = 1'b1;
        else if (capture) begin
            st_d.open  = 1'b0;
            st_d.valid = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.open  <= 1'b0;
            st_q.valid <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < int'(NR); g++) begin : g_ring
        localparam int unsigned LEN = mod_of(MODS, g);
        localparam int unsigned OFF = mods_offset(MODS, g);

        logic [LEN-1:0] cap;

        cid_ring #(.LEN(LEN)) u_ring (
            .clk     (clk),
            .rst_n   (rst_n),
            .clear   (clear),
            .adv     (adv),
            .capture (capture),
            .cap_o   (cap)
        );

        cid_decode #(.LEN(LEN), .RW(RW)) u_dec (
            .onehot (cap),
            .idx    (residue_o[g*RW +: RW])
        );

        assign ring_phase_o[OFF +: LEN] = cap;

        // R4: each residue stays inside its modulus
        a_r4_residue_range: assert property (@(posedge clk) disable iff (!rst_n)
            32'(residue_o[g*RW +: RW]) < LEN);

        // R4: the recombined count agrees with every residue
        a_r4_count_matches: assert property (@(posedge clk) disable iff (!rst_n)
            valid_o |-> ((32'(count_o) % LEN) == 32'(residue_o[g*RW +: RW])));
    end

    cid_combine #(.NR(NR), .MODS(MODS), .RW(RW), .KW(KW)) u_comb (
        .res_i (residue_o),
        .k_o   (count_o)
    );

    assign valid_o = st_q.valid;

    // R6: an accepted stop yields valid next cycle
    a_r6_valid_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && st_q.open && !start) |=> valid_o);

    // R6: valid is a single-cycle pulse
    a_r6_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R7: a stop with the window closed produces nothing
    a_r7_stray_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && !st_q.open && !start) |=> !valid_o);

    // R8: start and stop together keep the window open and give no result
    a_r8_start_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (start && stop) |=> (st_q.open && !valid_o));

endmodule

// File: tb/tb_crt_interval_digitizer.sv
module tb_crt_interval_digitizer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       start = 1'b0;
    logic       stop = 1'b0;
    logic [9:0] ring_phase_o;
    logic [8:0] residue_o;
    logic [4:0] count_o;
    logic       valid_o;

    int checks = 0;
    int errors = 0;
    int last_k = 0;

    always #10 clk = ~clk;

    crt_interval_digitizer dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_en      (tick_en),
        .start        (start),
        .stop         (stop),
        .ring_phase_o (ring_phase_o),
        .residue_o    (residue_o),
        .count_o      (count_o),
        .valid_o      (valid_o)
    );

    function automatic logic [9:0] exp_phase(int k);
        logic [9:0] v;
        v = '0;
        v[k % 2] = 1'b1;
        v[2 + k % 3] = 1'b1;
        v[5 + k % 5] = 1'b1;
        return v;
    endfunction

    function automatic logic [8:0] exp_res(int k);
        return {3'(k % 5), 3'(k % 3), 3'(k % 2)};
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic chk_result(int k, string req);
        chk(count_o == 5'(k), req, "count", int'(count_o), k);
        chk(residue_o == exp_res(k), "R4", "residues", int'(residue_o), int'(exp_res(k)));
        chk(ring_phase_o == exp_phase(k), "R5", "phases", int'(ring_phase_o), int'(exp_phase(k)));
    endtask

    // Open window (optionally colliding with stop), count n ticks, stop, check.
    task automatic measure(int n, bit collide);
        int cnt;
        @(negedge clk);
        start = 1'b1;
        stop = collide;
        tick_en = 1'($urandom % 2);
        @(negedge clk);
        start = 1'b0;
        stop = 1'b0;
        if (collide) chk(valid_o == 1'b0, "R8", "valid after start+stop", int'(valid_o), 0);
        cnt = 0;
        while (cnt < n) begin
            tick_en = ($urandom % 4) != 0;
            if (tick_en) cnt++;
            @(negedge clk);
        end
        stop = 1'b1;
        tick_en = 1'($urandom % 2);
        @(negedge clk);
        stop = 1'b0;
        tick_en = 1'b0;
        chk(valid_o == 1'b1, "R6", "valid after stop", int'(valid_o), 1);
        chk_result(n % 30, "R3");
        last_k = n % 30;
        @(negedge clk);
        chk(valid_o == 1'b0, "R6", "valid pulse width", int'(valid_o), 0);
    endtask

    // Random ticks and a stray stop with the window closed.
    task automatic idle_and_stray();
        repeat (1 + $urandom % 4) begin
            tick_en = 1'($urandom % 2);
            @(negedge clk);
        end
        tick_en = 1'b1;
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        tick_en = 1'b0;
        @(negedge clk);
        chk(valid_o == 1'b0, "R7", "valid on stray stop", int'(valid_o), 0);
        chk(count_o == 5'(last_k), "R7", "count held", int'(count_o), last_k);
        chk(ring_phase_o == exp_phase(last_k), "R2", "phases held while closed",
            int'(ring_phase_o), int'(exp_phase(last_k)));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(valid_o == 1'b0, "R1", "reset valid", int'(valid_o), 0);
        chk_result(0, "R1");
        rst_n = 1'b1;
        @(negedge clk);
        // R7: stop with no prior start
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        @(negedge clk);
        chk(valid_o == 1'b0, "R7", "valid on stop before start", int'(valid_o), 0);
        chk_result(0, "R7");
        // R3: linear sweep including wrap at 30
        for (int n = 0; n <= 35; n++) begin
            measure(n, 1'b0);
            idle_and_stray();
        end
        // R8: start and stop together
        measure(4, 1'b1);
        measure(29, 1'b1);
        // R3: random intervals
        for (int r = 0; r < 40; r++) begin
            measure(int'($urandom % 100), 1'($urandom % 5 == 0));
            if ($urandom % 2 == 0) idle_and_stray();
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule